// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the architectural state change that happens when a processor takes an exception or an interrupt. When the take request is raised, it does four things in the same clock edge. It copies the current program counter, the current status word and general register 15 into shadow registers. It records the event code in the interrupt-event register or the exception-event register. It produces a new status word with the privileged-mode, register-bank and block bits forced high. It produces a new program counter at a fixed offset of 0x100 above the vector base.

The interrupt code decides what kind of entry is taken. A nonzero interrupt code makes the entry an interrupt. A zero interrupt code makes it an exception, named by the exception code. Two exception codes get special treatment. The trap code advances the saved program counter past the 16-bit trap instruction, so a return resumes after it. The reserved-instruction code raises a flag next to the unmodified saved program counter. The address-translation codes also capture the faulting virtual address. If an entry is requested while the block bit is already set in the incoming status word, the entry still completes, and an error pulse is raised. A done pulse follows every request by one cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: On a take request, savedPc, savedSr and savedGr capture curPc, curSr and curR15 in the same clock edge (savedPc takes curPc unmodified unless R6 applies).
- R2: A take request with a nonzero intCode writes intCode to intEvent and leaves excEvent unchanged.
- R3: A take request with intCode equal to zero writes excCode to excEvent and leaves intEvent unchanged.
- R4: newSr becomes curSr with bits 30 (privileged mode), 29 (register bank) and 28 (block) forced to 1, and every other bit kept.
- R5: newPc becomes vecBase + 0x100 for every entry kind.
- R6: An exception entry with excCode 0x160 (trap) stores curPc + 2 in savedPc.
- R7: If curSr bit 28 is 1 when a take request is sampled, blockErr is 1 in the cycle after the request, and it is 0 otherwise. The entry itself still completes.
- R8: An exception entry with excCode 0x180 (reserved instruction) sets resvFlag to 1 in the cycle after the request, with savedPc equal to curPc. Every other entry leaves resvFlag at 0.
- R9: An exception entry with excCode 0x040, 0x060, 0x080, 0x0A0 or 0x0C0 (address translation) loads faultAddr into faultVa. Any other entry leaves faultVa unchanged.
- R10: entryDone is 1 exactly in the cycle after each sampled take request. Without a take request, every output register holds its value.
- R11: When intCode is nonzero, the entry is an interrupt even if excCode holds the trap, reserved or translation code. In that case there is no +2 adjust, no resvFlag and no faultVa capture.
- R12: While rstN is low (active-low reset), every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| takeReq | input | 1 | Take an exception or interrupt this cycle |
| excCode | input | 12 | Exception event code |
| intCode | input | 12 | Interrupt event code, nonzero means interrupt |
| faultAddr | input | 32 | Faulting virtual address |
| curPc | input | 32 | Current program counter |
| curSr | input | 32 | Current status word |
| curR15 | input | 32 | Current general register 15 |
| vecBase | input | 32 | Vector base register |
| savedPc | output | 32 | Shadow program counter |
| savedSr | output | 32 | Shadow status word |
| savedGr | output | 32 | Shadow general register |
| intEvent | output | 12 | Interrupt-event register |
| excEvent | output | 12 | Exception-event register |
| faultVa | output | 32 | Captured faulting address |
| newSr | output | 32 | Status word after entry |
| newPc | output | 32 | Program counter after entry |
| entryDone | output | 1 | Entry completed, one-cycle pulse |
| blockErr | output | 1 | Entry requested with block bit already set |
| resvFlag | output | 1 | Entry was a reserved-instruction exception |

## Verification
Every result of an entry becomes visible at the first rising edge after the request is sampled. This holds for all three shadow registers, both event registers, the captured address, the new status word, the new program counter and the three pulses. The bench drives each request on a falling edge and reads every output on the next falling edge, half a period after the commit edge. It then lowers the request and reads again one cycle later. This second read confirms that the pulses have cleared and that the state registers have held.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] CODE_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] CODE_RESV     = 12'h180;
  localparam logic [CODE_W-1:0] CODE_TLB_RD   = 12'h040;
  localparam logic [CODE_W-1:0] CODE_TLB_WR   = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TLB_INIT = 12'h080;
  localparam logic [CODE_W-1:0] CODE_PROT_RD  = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_PROT_WR  = 12'h0C0;

  localparam int BIT_MD = 30;
  localparam int BIT_RB = 29;
  localparam int BIT_BL = 28;

  typedef struct packed {
    logic loadShadow;
    logic loadIntEvt;
    logic loadExcEvt;
    logic loadFault;
    logic trapAdjust;
  } entry_strobe_t;

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int CODE_BITS = CODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 takeReq,
  input  logic [CODE_BITS-1:0] excCode,
  input  logic [CODE_BITS-1:0] intCode,
  input  logic                 blockBit,
  output entry_strobe_t        strobe,
  output logic                 entryDone,
  output logic                 blockErr,
  output logic                 resvFlag
);

  logic isInterrupt;
  logic isTrap;
  logic isResv;
  logic isXlate;

  function automatic logic xlateCode(input logic [CODE_BITS-1:0] c);
    logic hit;
    hit = 1'b0;
    if (c == CODE_BITS'(CODE_TLB_RD))   hit = 1'b1;
    if (c == CODE_BITS'(CODE_TLB_WR))   hit = 1'b1;
    if (c == CODE_BITS'(CODE_TLB_INIT)) hit = 1'b1;
    if (c == CODE_BITS'(CODE_PROT_RD))  hit = 1'b1;
    if (c == CODE_BITS'(CODE_PROT_WR))  hit = 1'b1;
    return hit;
  endfunction

  always_comb begin
    isInterrupt = (intCode != '0);
    isTrap      = !isInterrupt && (excCode == CODE_BITS'(CODE_TRAP));
    isResv      = !isInterrupt && (excCode == CODE_BITS'(CODE_RESV));
    isXlate     = !isInterrupt && xlateCode(excCode);
  end

  always_comb begin
    strobe            = '0;
    strobe.loadShadow = takeReq;
    strobe.loadIntEvt = takeReq && isInterrupt;
    strobe.loadExcEvt = takeReq && !isInterrupt;
    strobe.loadFault  = takeReq && isXlate;
    strobe.trapAdjust = isTrap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryDone <= 1'b0;
      blockErr  <= 1'b0;
      resvFlag  <= 1'b0;
    end else begin
      entryDone <= takeReq;
      blockErr  <= takeReq && blockBit;
      resvFlag  <= takeReq && isResv;
    end
  end

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_BITS = CODE_W,
  parameter int VEC_OFF   = 'h100,
  parameter int INSN_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  entry_strobe_t        strobe,
  input  logic [CODE_BITS-1:0] excCode,
  input  logic [CODE_BITS-1:0] intCode,
  input  logic [XLEN-1:0]      faultAddr,
  input  logic [XLEN-1:0]      curPc,
  input  logic [XLEN-1:0]      curSr,
  input  logic [XLEN-1:0]      curR15,
  input  logic [XLEN-1:0]      vecBase,
  output logic [XLEN-1:0]      savedPc,
  output logic [XLEN-1:0]      savedSr,
  output logic [XLEN-1:0]      savedGr,
  output logic [CODE_BITS-1:0] intEvent,
  output logic [CODE_BITS-1:0] excEvent,
  output logic [XLEN-1:0]      faultVa,
  output logic [XLEN-1:0]      newSr,
  output logic [XLEN-1:0]      newPc
);

  localparam logic [XLEN-1:0] FORCE_MASK =
    (XLEN'(1) << BIT_MD) | (XLEN'(1) << BIT_RB) | (XLEN'(1) << BIT_BL);

  logic [XLEN-1:0] pcStep;
  logic [XLEN-1:0] pcToSave;
  logic [XLEN-1:0] vectorPc;

  always_comb begin
    pcStep   = strobe.trapAdjust ? XLEN'(INSN_BYTES) : '0;
    pcToSave = curPc + pcStep;
    vectorPc = vecBase + XLEN'(VEC_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPc <= '0;
      savedSr <= '0;
      savedGr <= '0;
      newSr   <= '0;
      newPc   <= '0;
    end else if (strobe.loadShadow) begin
      savedPc <= pcToSave;
      savedSr <= curSr;
      savedGr <= curR15;
      newSr   <= curSr | FORCE_MASK;
      newPc   <= vectorPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEvent <= '0;
      excEvent <= '0;
    end else begin
      if (strobe.loadIntEvt) intEvent <= intCode;
      if (strobe.loadExcEvt) excEvent <= excCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) faultVa <= '0;
    else if (strobe.loadFault) faultVa <= faultAddr;
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_BITS = CODE_W,
  parameter int VEC_OFF   = 'h100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 takeReq,
  input  logic [CODE_BITS-1:0] excCode,
  input  logic [CODE_BITS-1:0] intCode,
  input  logic [XLEN-1:0]      faultAddr,
  input  logic [XLEN-1:0]      curPc,
  input  logic [XLEN-1:0]      curSr,
  input  logic [XLEN-1:0]      curR15,
  input  logic [XLEN-1:0]      vecBase,
  output logic [XLEN-1:0]      savedPc,
  output logic [XLEN-1:0]      savedSr,
  output logic [XLEN-1:0]      savedGr,
  output logic [CODE_BITS-1:0] intEvent,
  output logic [CODE_BITS-1:0] excEvent,
  output logic [XLEN-1:0]      faultVa,
  output logic [XLEN-1:0]      newSr,
  output logic [XLEN-1:0]      newPc,
  output logic                 entryDone,
  output logic                 blockErr,
  output logic                 resvFlag
);

  entry_strobe_t strobe;

  exc_entry_ctrl #(.CODE_BITS(CODE_BITS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .takeReq   (takeReq),
    .excCode   (excCode),
    .intCode   (intCode),
    .blockBit  (curSr[BIT_BL]),
    .strobe    (strobe),
    .entryDone (entryDone),
    .blockErr  (blockErr),
    .resvFlag  (resvFlag)
  );

  exc_entry_dp #(
    .XLEN      (XLEN),
    .CODE_BITS (CODE_BITS),
    .VEC_OFF   (VEC_OFF),
    .INSN_BYTES(2)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .excCode   (excCode),
    .intCode   (intCode),
    .faultAddr (faultAddr),
    .curPc     (curPc),
    .curSr     (curSr),
    .curR15    (curR15),
    .vecBase   (vecBase),
    .savedPc   (savedPc),
    .savedSr   (savedSr),
    .savedGr   (savedGr),
    .intEvent  (intEvent),
    .excEvent  (excEvent),
    .faultVa   (faultVa),
    .newSr     (newSr),
    .newPc     (newPc)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_BITS = CODE_W,
  parameter int VEC_OFF   = 'h100
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 takeReq,
  input logic [CODE_BITS-1:0] intCode,
  input logic [XLEN-1:0]      curPc,
  input logic [XLEN-1:0]      curSr,
  input logic [XLEN-1:0]      vecBase,
  input logic [XLEN-1:0]      savedSr,
  input logic [CODE_BITS-1:0] excEvent,
  input logic [XLEN-1:0]      newSr,
  input logic [XLEN-1:0]      newPc,
  input logic                 entryDone,
  input logic                 blockErr
);

  localparam logic [XLEN-1:0] HIGH_BITS =
    (XLEN'(1) << BIT_MD) | (XLEN'(1) << BIT_RB) | (XLEN'(1) << BIT_BL);

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |=> entryDone);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    !takeReq |=> !entryDone);

  p_hold_pc_r10: assert property (@(posedge clk) disable iff (!rstN)
    !takeReq |=> $stable(newPc));

  p_sr_force_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |=> newSr == ($past(curSr) | HIGH_BITS));

  p_shadow_sr_r1: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |=> savedSr == $past(curSr));

  p_vector_r5: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |=> newPc == $past(vecBase) + XLEN'(VEC_OFF));

  p_int_keeps_exc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && intCode != '0) |=> $stable(excEvent));

  p_block_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && curSr[BIT_BL]) |=> blockErr);

  p_no_spurious_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(takeReq && curSr[BIT_BL]) |=> !blockErr);

  logic unusedPc;
  assign unusedPc = ^curPc;

endmodule

bind exc_entry_seq exc_entry_chk #(
  .XLEN(XLEN), .CODE_BITS(CODE_BITS), .VEC_OFF(VEC_OFF)
) chk_i (
  .clk(clk), .rstN(rstN), .takeReq(takeReq), .intCode(intCode),
  .curPc(curPc), .curSr(curSr), .vecBase(vecBase), .savedSr(savedSr),
  .excEvent(excEvent), .newSr(newSr), .newPc(newPc),
  .entryDone(entryDone), .blockErr(blockErr)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] sr;
    logic [31:0] r15;
    logic [31:0] vbr;
    logic [11:0] ic;
    logic [11:0] ec;
    logic [31:0] fa;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{32'h8C00_1000, 32'h0000_00F0, 32'h0000_AAAA, 32'h8C00_0000, 12'h000, 12'h1E0, 32'h1111_0000},
    '{32'h8C00_2002, 32'h4000_0001, 32'h0000_BBBB, 32'h8000_0000, 12'h200, 12'h000, 32'h2222_0000},
    '{32'h8C00_3004, 32'h0000_0000, 32'h0000_CCCC, 32'h8C10_0000, 12'h000, 12'h160, 32'h3333_0000},
    '{32'h8C00_4006, 32'h0000_0300, 32'h0000_DDDD, 32'h8C20_0000, 12'h000, 12'h180, 32'h4444_0000},
    '{32'h8C00_5008, 32'h0000_0002, 32'h0000_EEEE, 32'h8C30_0000, 12'h000, 12'h040, 32'h5555_1234},
    '{32'h8C00_600A, 32'h0000_0010, 32'h0000_1212, 32'h8C40_0000, 12'h3C0, 12'h160, 32'h6666_0000},
    '{32'h8C00_700C, 32'h1000_0000, 32'h0000_3434, 32'h8C50_0000, 12'h000, 12'h0C0, 32'h7777_5678},
    '{32'h8C00_800E, 32'h0000_0004, 32'h0000_5656, 32'hFFFF_FF80, 12'h000, 12'h100, 32'h8888_0000}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        takeReq;
  logic [11:0] excCode, intCode;
  logic [31:0] faultAddr, curPc, curSr, curR15, vecBase;
  logic [31:0] savedPc, savedSr, savedGr, faultVa, newSr, newPc;
  logic [11:0] intEvent, excEvent;
  logic        entryDone, blockErr, resvFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [31:0] expPc, expInt, expExc, expFault;

  always #4 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rstN(rstN), .takeReq(takeReq), .excCode(excCode),
    .intCode(intCode), .faultAddr(faultAddr), .curPc(curPc), .curSr(curSr),
    .curR15(curR15), .vecBase(vecBase), .savedPc(savedPc), .savedSr(savedSr),
    .savedGr(savedGr), .intEvent(intEvent), .excEvent(excEvent),
    .faultVa(faultVa), .newSr(newSr), .newPc(newPc), .entryDone(entryDone),
    .blockErr(blockErr), .resvFlag(resvFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic bit isXlate(input logic [11:0] c);
    return c == 12'h040 || c == 12'h060 || c == 12'h080 || c == 12'h0A0 || c == 12'h0C0;
  endfunction

  task automatic runEntry(input vec_t v);
    bit isInt;
    isInt = (v.ic != 12'h000);
    @(negedge clk);
    curPc = v.pc; curSr = v.sr; curR15 = v.r15; vecBase = v.vbr;
    intCode = v.ic; excCode = v.ec; faultAddr = v.fa; takeReq = 1'b1;
    if (isInt) expInt = {20'h0, v.ic};
    else expExc = {20'h0, v.ec};
    if (!isInt && isXlate(v.ec)) expFault = v.fa;
    expPc = (!isInt && v.ec == 12'h160) ? v.pc + 32'd2 : v.pc;
    @(negedge clk);
    takeReq = 1'b0;
    check("R1 savedPc (R6 trap, R11 precedence)", savedPc, expPc);
    check("R1 savedSr", savedSr, v.sr);
    check("R1 savedGr", savedGr, v.r15);
    check("R4 newSr", newSr, v.sr | 32'h7000_0000);
    check("R5 newPc", newPc, v.vbr + 32'h100);
    check("R2 intEvent", {20'h0, intEvent}, expInt);
    check("R3 excEvent", {20'h0, excEvent}, expExc);
    check("R9 faultVa (R11)", faultVa, expFault);
    check("R10 entryDone pulse", {31'h0, entryDone}, 32'd1);
    check("R7 blockErr", {31'h0, blockErr}, {31'h0, v.sr[28]});
    check("R8 resvFlag (R11)", {31'h0, resvFlag}, {31'h0, (!isInt && v.ec == 12'h180)});
    curPc = 32'hDEAD_0000; curSr = 32'h1000_0000; vecBase = 32'h1234_5678;
    intCode = 12'h5A0; excCode = 12'h040; faultAddr = 32'hBAD0_BAD0;
    @(negedge clk);
    check("R10 entryDone clears", {31'h0, entryDone}, 32'd0);
    check("R10 newPc holds", newPc, v.vbr + 32'h100);
    check("R10 savedPc holds", savedPc, expPc);
    check("R10 faultVa holds", faultVa, expFault);
    check("R10 intEvent holds", {20'h0, intEvent}, expInt);
    check("R7 blockErr clears without request", {31'h0, blockErr}, 32'd0);
    check("R8 resvFlag clears", {31'h0, resvFlag}, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
        $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0; takeReq = 1'b0; excCode = '0; intCode = '0; faultAddr = '0;
    curPc = 32'hFFFF_FFFF; curSr = 32'hFFFF_FFFF; curR15 = 32'hFFFF_FFFF;
    vecBase = 32'hFFFF_FFFF;
    expInt = '0; expExc = '0; expFault = '0; expPc = '0;
    repeat (3) @(negedge clk);
    takeReq = 1'b1;
    @(negedge clk);
    check("R12 reset savedPc", savedPc, 32'h0);
    check("R12 reset newSr", newSr, 32'h0);
    check("R12 reset newPc", newPc, 32'h0);
    check("R12 reset faultVa", faultVa, 32'h0);
    check("R12 reset flags", {29'h0, entryDone, blockErr, resvFlag}, 32'h0);
    check("R12 reset events", {8'h0, intEvent, excEvent}, 32'h0);
    takeReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R10 no request no done", {31'h0, entryDone}, 32'd0);
    for (int i = 0; i < NVEC; i++) runEntry(TBL[i]);
    // back-to-back: interrupt then translation exception on the next cycle
    @(negedge clk);
    curPc = 32'h0000_0100; curSr = 32'h0; curR15 = 32'h77; vecBase = 32'h0;
    intCode = 12'h240; excCode = 12'h060; faultAddr = 32'hCAFE_0000; takeReq = 1'b1;
    @(negedge clk);
    check("R11 interrupt skips fault capture", faultVa, expFault);
    check("R2 intEvent back-to-back", {20'h0, intEvent}, 32'h240);
    intCode = 12'h000;
    @(negedge clk);
    takeReq = 1'b0;
    check("R9 fault capture on 0x060", faultVa, 32'hCAFE_0000);
    check("R3 excEvent 0x060", {20'h0, excEvent}, 32'h060);
    check("R2 intEvent kept by exception", {20'h0, intEvent}, 32'h240);
    check("R10 done stays for second request", {31'h0, entryDone}, 32'd1);
    @(negedge clk);
    check("R10 done drops", {31'h0, entryDone}, 32'd0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule